// File: doc/BRIEF.md
# Receive Frame Address Filter

This block decides whether an incoming network frame is kept, based on the frame's destination address. Bytes arrive one per cycle with a start marker on the first byte. A separate end strobe carries the total frame length. The first six bytes form the destination address. They are compared on the fly against a station address, the all-ones broadcast pattern, the multicast bit and a fixed reset-packet pattern.

One cycle after the end strobe, the block presents its results and holds them until the next start marker:
- an accept/reject decision;
- a runt flag for frames shorter than 64 bytes;
- a reset-packet flag.

A host writes the station address one byte at a time. An 8-bit receive-mode word picks the acceptance policy.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is asserted, and at any time decisionValid is low, accept, runtFlag and resetPktFlag are 0.
- R2: The cycle after eof, decisionValid is 1 together with accept, runtFlag and resetPktFlag. These four hold steady until a cycle with sof. The cycle after sof, all four are 0.
- R3: With rxMode[1:0] = 00, no frame is accepted, with the single exception given in R9.
- R4: With rxMode[1:0] = 01, a frame is accepted if its destination equals the station address or is FF:FF:FF:FF:FF:FF. Any other destination, including a multicast, is rejected.
- R5: With rxMode[1:0] = 10, frames accepted under R4 are still accepted. In addition, any destination whose first byte has bit 0 set is accepted.
- R6: With rxMode[1:0] = 11, every frame of at least 64 bytes is accepted.
- R7: A frameLen below 64 sets runtFlag. Such a frame is rejected unless rxMode[3] is 1. A length of 64 is not a runt.
- R8: With rxMode[4] = 1, only destination bytes 0 to 4 are compared with the station address. Byte 5 is ignored.
- R9: The destination FE:5A:A5:C3:3C:0F sets resetPktFlag in every mode. With rxMode[2] = 1, that frame is accepted whatever rxMode[1:0] holds (subject to R7).
- R10: rxMode[7] has no effect on any output.
- R11: A host write with hostAddr 0 to 5 loads station byte hostAddr, and that byte is compared with destination byte hostAddr (byte 0 is the first on the wire). Writes to hostAddr 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe for the station address |
| hostAddr | input | 3 | Station byte index for a host write |
| hostWrData | input | 8 | Station byte value |
| rxMode | input | 8 | Receive mode: [1:0] policy, [2] reset-packet enable, [3] runt enable, [4] five-byte match, [7] test |
| sof | input | 1 | Marks the first byte of a frame (with byteValid) |
| byteValid | input | 1 | byteData holds a frame byte |
| byteData | input | 8 | Frame byte |
| eof | input | 1 | Frame end strobe, after the last byte |
| frameLen | input | 11 | Frame length in bytes, valid with eof |
| decisionValid | output | 1 | Results are valid |
| accept | output | 1 | Frame accepted |
| runtFlag | output | 1 | Frame was a runt |
| resetPktFlag | output | 1 | Frame carried the reset-packet destination |

## Verification
The assertions check the handshake timing on every cycle:
- results appear after eof, stay stable while held, and clear after sof;
- outputs stay quiet while no decision is valid;
- mode 00 rejects, promiscuous mode accepts full-size frames, and runts are flagged and dropped when runts are not enabled.

Address matching depends on the station contents and the destination bytes, so only the bench scenarios show it. These scenarios cover own, broadcast, multicast, reset-pattern and five-byte matching, the 63/64 length boundary, the test bit and ignored host addresses.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int MODE_RST_EN  = 2;
  localparam int MODE_RUNT_EN = 3;
  localparam int MODE_ADDR5   = 4;

  typedef struct packed {
    logic clearAcc;
    logic takeByte;
    logic latchDec;
    logic clearDec;
  } rxfStrobe_t;

  typedef struct packed {
    logic own;
    logic bcast;
    logic mcast;
    logic rstPat;
    logic destDone;
  } rxfAccum_t;

endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int IDX_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sof,
  input  logic             byteValid,
  input  logic             eof,
  output rxfStrobe_t       strobe,
  output logic [IDX_W-1:0] curIdx,
  output logic             decValid
);

  logic [IDX_W-1:0] byteIdx;

  always_comb begin
    strobe.clearAcc = sof;
    strobe.takeByte = byteValid;
    strobe.latchDec = eof;
    strobe.clearDec = sof & ~eof;
    curIdx = sof ? '0 : byteIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
    end else if (byteValid) begin
      if (curIdx != IDX_W'(ADDR_BYTES)) byteIdx <= curIdx + IDX_W'(1);
      else                              byteIdx <= curIdx;
    end else if (sof) begin
      byteIdx <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    decValid <= 1'b0;
    else if (eof) decValid <= 1'b1;
    else if (sof) decValid <= 1'b0;
  end

endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int MIN_LEN = 64,
  parameter int LEN_W = 11,
  parameter logic [8*ADDR_BYTES-1:0] RST_PATTERN = 48'hFE5AA5C33C0F,
  localparam int IDX_W = $clog2(ADDR_BYTES + 1),
  localparam int HADDR_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  rxfStrobe_t         strobe,
  input  logic [IDX_W-1:0]   curIdx,
  input  logic [7:0]         byteData,
  input  logic [LEN_W-1:0]   frameLen,
  input  logic [7:0]         rxMode,
  input  logic               hostWrEn,
  input  logic [HADDR_W-1:0] hostAddr,
  input  logic [7:0]         hostWrData,
  output logic               accept,
  output logic               runtFlag,
  output logic               resetPktFlag
);

  localparam rxfAccum_t ACC_INIT = '{own: 1'b1, bcast: 1'b1, mcast: 1'b0,
                                     rstPat: 1'b1, destDone: 1'b0};

  logic [7:0] stnByte [ADDR_BYTES];
  logic [7:0] patByte [ADDR_BYTES];

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_station
    assign patByte[g] = RST_PATTERN[8*(ADDR_BYTES-1-g) +: 8];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stnByte[g] <= 8'h00;
      else if (hostWrEn && hostAddr == HADDR_W'(g))
        stnByte[g] <= hostWrData;
    end
  end

  rxfAccum_t accReg, accBase, accNext;
  logic [7:0] stnSel, patSel;
  int cmpLimit;

  always_comb begin
    stnSel = 8'h00;
    patSel = 8'h00;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (curIdx == IDX_W'(i)) begin
        stnSel = stnByte[i];
        patSel = patByte[i];
      end
    end
  end

  always_comb begin
    cmpLimit = rxMode[MODE_ADDR5] ? ADDR_BYTES - 1 : ADDR_BYTES;
    accBase = strobe.clearAcc ? ACC_INIT : accReg;
    accNext = accBase;
    if (strobe.takeByte && int'(curIdx) < ADDR_BYTES) begin
      accNext.own    = accBase.own & ((int'(curIdx) >= cmpLimit) || byteData == stnSel);
      accNext.bcast  = accBase.bcast & (byteData == 8'hFF);
      accNext.rstPat = accBase.rstPat & (byteData == patSel);
      if (curIdx == '0) accNext.mcast = byteData[0];
      if (curIdx == IDX_W'(ADDR_BYTES - 1)) accNext.destDone = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accReg <= ACC_INIT;
    else       accReg <= accNext;
  end

  logic ownHit, bcHit, rstHit, mcHit, addrOk, isRunt, acceptNext;

  always_comb begin
    ownHit = accReg.own & accReg.destDone;
    bcHit  = accReg.bcast & accReg.destDone;
    rstHit = accReg.rstPat & accReg.destDone;
    mcHit  = accReg.mcast;
    unique case (rxMode[1:0])
      2'b00:   addrOk = 1'b0;
      2'b01:   addrOk = bcHit | ownHit;
      2'b10:   addrOk = bcHit | ownHit | mcHit;
      default: addrOk = 1'b1;
    endcase
    isRunt = frameLen < LEN_W'(MIN_LEN);
    acceptNext = (addrOk | (rstHit & rxMode[MODE_RST_EN])) &
                 (~isRunt | rxMode[MODE_RUNT_EN]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accept       <= 1'b0;
      runtFlag     <= 1'b0;
      resetPktFlag <= 1'b0;
    end else if (strobe.latchDec) begin
      accept       <= acceptNext;
      runtFlag     <= isRunt;
      resetPktFlag <= rstHit;
    end else if (strobe.clearDec) begin
      accept       <= 1'b0;
      runtFlag     <= 1'b0;
      resetPktFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int MIN_LEN = 64,
  parameter int LEN_W = 11,
  parameter logic [8*ADDR_BYTES-1:0] RST_PATTERN = 48'hFE5AA5C33C0F,
  localparam int HADDR_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [HADDR_W-1:0] hostAddr,
  input  logic [7:0]         hostWrData,
  input  logic [7:0]         rxMode,
  input  logic               sof,
  input  logic               byteValid,
  input  logic [7:0]         byteData,
  input  logic               eof,
  input  logic [LEN_W-1:0]   frameLen,
  output logic               decisionValid,
  output logic               accept,
  output logic               runtFlag,
  output logic               resetPktFlag
);

  localparam int IDX_W = $clog2(ADDR_BYTES + 1);

  rxfStrobe_t       strobe;
  logic [IDX_W-1:0] curIdx;

  rxf_ctrl #(.ADDR_BYTES(ADDR_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sof(sof), .byteValid(byteValid), .eof(eof),
    .strobe(strobe), .curIdx(curIdx), .decValid(decisionValid)
  );

  rxf_datapath #(
    .ADDR_BYTES(ADDR_BYTES), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W),
    .RST_PATTERN(RST_PATTERN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curIdx(curIdx),
    .byteData(byteData), .frameLen(frameLen), .rxMode(rxMode),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .accept(accept), .runtFlag(runtFlag), .resetPktFlag(resetPktFlag)
  );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int MIN_LEN = 64,
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             sof,
  input logic             eof,
  input logic [LEN_W-1:0] frameLen,
  input logic [7:0]       rxMode,
  input logic             decisionValid,
  input logic             accept,
  input logic             runtFlag,
  input logic             resetPktFlag
);

  AST_DECISION_AFTER_EOF: assert property (@(posedge clk) disable iff (!rstN)
    eof |=> decisionValid); // R2

  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    sof && !eof |=> !decisionValid && !accept && !runtFlag && !resetPktFlag); // R2

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid && !sof && !eof |=>
      decisionValid && $stable(accept) && $stable(runtFlag) && $stable(resetPktFlag)); // R2

  AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    !decisionValid |-> !accept && !runtFlag && !resetPktFlag); // R1

  AST_FIELD_NONE: assert property (@(posedge clk) disable iff (!rstN)
    eof && rxMode[1:0] == 2'b00 && !rxMode[2] |=> !accept); // R3

  AST_PROMISC_FULL: assert property (@(posedge clk) disable iff (!rstN)
    eof && rxMode[1:0] == 2'b11 && frameLen >= LEN_W'(MIN_LEN) |=> accept); // R6

  AST_RUNT_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    eof |=> runtFlag == ($past(frameLen) < LEN_W'(MIN_LEN))); // R7

  AST_RUNT_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    eof && frameLen < LEN_W'(MIN_LEN) && !rxMode[3] |=> !accept); // R7

endmodule

bind rx_addr_filter rxf_checker #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rstN(rstN), .sof(sof), .eof(eof), .frameLen(frameLen),
  .rxMode(rxMode), .decisionValid(decisionValid), .accept(accept),
  .runtFlag(runtFlag), .resetPktFlag(resetPktFlag)
);

// File: tb/rx_addr_filter_tb_top.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;

  localparam logic [47:0] PAT = 48'hFE5AA5C33C0F;
  localparam logic [47:0] BCAST = 48'hFFFFFFFFFFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic [7:0] rxMode = '0;
  logic sof = 1'b0, byteValid = 1'b0, eof = 1'b0;
  logic [7:0] byteData = '0;
  logic [10:0] frameLen = '0;
  logic decisionValid, accept, runtFlag, resetPktFlag;

  always #2.5 clk = ~clk;

  rx_addr_filter dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .rxMode(rxMode), .sof(sof), .byteValid(byteValid),
    .byteData(byteData), .eof(eof), .frameLen(frameLen),
    .decisionValid(decisionValid), .accept(accept), .runtFlag(runtFlag),
    .resetPktFlag(resetPktFlag)
  );

  typedef struct {
    bit acc;
    bit runt;
    bit rst;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  logic [47:0] stnModel = '0;
  bit pend = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic expItem_t model(input logic [47:0] d, input int len,
                                     input logic [7:0] m, input string r);
    expItem_t e;
    bit full, own, bc, mc, rp, ok;
    full = len >= 6;
    own = full && (m[4] ? d[47:8] == stnModel[47:8] : d == stnModel);
    bc = full && d == BCAST;
    mc = d[40];
    rp = full && d == PAT;
    case (m[1:0])
      2'b00: ok = 0;
      2'b01: ok = bc || own;
      2'b10: ok = bc || own || mc;
      default: ok = 1;
    endcase
    e.acc = (ok || (rp && m[2])) && (len >= 64 || m[3]);
    e.runt = len < 64;
    e.rst = rp;
    e.req = r;
    return e;
  endfunction

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] v);
    hostWrEn = 1; hostAddr = a; hostWrData = v;
    @(posedge clk); #1;
    hostWrEn = 0;
    if (a < 6) stnModel[8*(5-a) +: 8] = v;
  endtask

  task automatic setStation(input logic [47:0] s);
    for (int i = 0; i < 6; i++) hostWrite(3'(i), s[8*(5-i) +: 8]);
  endtask

  task automatic sendFrame(input logic [47:0] d, input int len,
                           input logic [7:0] m, input string r);
    expItem_t e;
    int nB;
    e = model(d, len, m, r);
    expQ.push_back(e);
    rxMode = m;
    nB = (len < 8) ? len : 8;
    for (int i = 0; i < nB; i++) begin
      sof = (i == 0);
      byteValid = 1;
      byteData = (i < 6) ? d[8*(5-i) +: 8] : 8'h77;
      @(posedge clk); #1;
      if (i == 0) begin
        // R2: decision cleared the cycle after sof
        check(!decisionValid && !accept && !runtFlag && !resetPktFlag, "R2",
              "cleared after sof", decisionValid, 0);
      end
    end
    sof = 0; byteValid = 0;
    eof = 1; frameLen = 11'(len);
    @(posedge clk); #1;
    eof = 0;
    repeat (3) begin @(posedge clk); #1; end
    // R2: results held while idle
    check(decisionValid && accept == e.acc && runtFlag == e.runt &&
          resetPktFlag == e.rst, "R2", "held result accept",
          accept, e.acc);
  endtask

  // Monitor: pops expected results one cycle after eof is captured
  initial begin
    forever begin
      @(negedge clk);
      if (pend) begin
        expItem_t e;
        pend = 0;
        if (expQ.size() == 0) begin
          check(0, "R2", "unexpected result", 1, 0);
        end else begin
          e = expQ.pop_front();
          check(decisionValid == 1, e.req, "decisionValid", decisionValid, 1);
          check(accept == e.acc, e.req, "accept", accept, e.acc);
          check(runtFlag == e.runt, e.req, "runtFlag", runtFlag, e.runt);
          check(resetPktFlag == e.rst, e.req, "resetPktFlag", resetPktFlag, e.rst);
        end
      end
      if (eof) pend = 1;
    end
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [47:0] STN = 48'h020701ABCDEF;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet under reset
    check(!decisionValid && !accept && !runtFlag && !resetPktFlag, "R1",
          "reset outputs", accept, 0);
    rstN = 1;
    @(posedge clk); #1;
    setStation(STN);

    sendFrame(STN, 100, 8'h01, "R4");
    sendFrame(BCAST, 100, 8'h01, "R4");
    sendFrame(48'h0A1122334455, 100, 8'h01, "R4");
    sendFrame(48'h030000000001, 100, 8'h01, "R4");
    sendFrame(48'h030000000001, 100, 8'h02, "R5");
    sendFrame(48'h0A1122334455, 100, 8'h02, "R5");
    sendFrame(STN, 100, 8'h02, "R5");
    sendFrame(STN, 100, 8'h00, "R3");
    sendFrame(BCAST, 100, 8'h00, "R3");
    sendFrame(48'h0A1122334455, 100, 8'h03, "R6");
    sendFrame(48'h0A1122334455, 40, 8'h03, "R7");
    sendFrame(48'h0A1122334455, 40, 8'h0B, "R7");
    sendFrame(STN, 63, 8'h01, "R7");
    sendFrame(STN, 64, 8'h01, "R7");
    sendFrame({STN[47:8], 8'h00}, 100, 8'h01, "R8");
    sendFrame({STN[47:8], 8'h00}, 100, 8'h11, "R8");
    sendFrame({STN[47:16], 8'h00, STN[7:0]}, 100, 8'h11, "R8");
    sendFrame(PAT, 100, 8'h00, "R9");
    sendFrame(PAT, 100, 8'h04, "R9");
    sendFrame(PAT, 100, 8'h01, "R9");
    sendFrame(PAT, 40, 8'h04, "R9");
    sendFrame(STN, 100, 8'h81, "R10");
    sendFrame(STN, 100, 8'h80, "R10");
    sendFrame(48'h0A1122334455, 40, 8'h8B, "R10");
    hostWrite(3'd6, 8'h00);
    hostWrite(3'd7, 8'h00);
    sendFrame(STN, 100, 8'h01, "R11");
    hostWrite(3'd5, 8'h99);
    sendFrame(STN, 100, 8'h01, "R11");
    sendFrame({STN[47:8], 8'h99}, 100, 8'h01, "R11");
    hostWrite(3'd0, 8'h44);
    sendFrame({8'h44, STN[39:8], 8'h99}, 100, 8'h01, "R11");

    repeat (3) begin @(posedge clk); #1; end
    check(expQ.size() == 0, "R2", "results outstanding", expQ.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule